// File: doc/BRIEF.md
# Burst Power-Control Switch Sequencer

This block steps the analog switches and the two output-driver enables of a dual-band transmit power-control loop through one time-division burst. A host raises the power-up level for each slot it transmits and drops it afterwards. An external comparator reports through a digital flag that the host's ramp has begun. Band select chooses which of the two output drivers serves the burst. The value is captured at the start of the burst, so the driver that is not in use stays powered down with its output clamped low until power-up falls.

A burst moves through five phases. In sampling, the detector offset is stored and the output is held at the pre-bias level. In armed, the block waits for a ramp. In home-settle, the output moves to the home voltage for a fixed number of cycles. In closed-loop, the feedback path is handed over to the loop. In disabled, both outputs are clamped. The sampling and settle lengths are parameters counted in clock cycles. A clock of at least 1 MHz keeps the response to the ramp and to power-up loss inside the microsecond limits of the loop. The phase is reported on a status port.

Top module: `burst_seq_top`

## Requirements
- R1: During reset and in the disabled phase (phase code 0), every switch control is 0 (open), both driver enables are 0 and both clamp outputs are 1. An active-low reset forces this state at once.
- R2: Band select is captured in the cycle that a burst starts. Value 0 selects the low band (`*_lo_*` ports) and value 1 selects the high band (`*_hi_*` ports). Changes to band select while the burst runs have no effect.
- R3: For the whole burst, the unselected band has its driver enable at 0, its feedback switch at 0 and its clamp at 1.
- R4: Power-up sampled high in the disabled phase enters sampling (code 1) on the next cycle. In sampling, the sample and pre-bias switches are 1, the selected feedback switch is 1, the home and transfer switches are 0, the selected driver is enabled and its clamp is 0.
- R5: Sampling lasts exactly SAMPLE_CYC cycles and then enters armed (code 2). In armed, the sample switch is 0 and the pre-bias and selected feedback switches stay at 1.
- R6: In armed, a rising edge on ramp-detected enters home-settle (code 3) on the next cycle. In that one step, the pre-bias switch goes to 0 and the home switch goes to 1.
- R7: Home-settle lasts exactly SETTLE_CYC cycles, however long the block waited in armed. It then enters closed-loop (code 4), where the selected feedback switch is 0 and the transfer switch is 1 in the same cycle, and the home switch stays 1.
- R8: A ramp-detected edge outside armed has no effect. A level that is already high when arming occurs does not count as an edge.
- R9: Power-up sampled low in any phase gives the disabled phase with R1 outputs on the next cycle.
- R10: Closed-loop persists while power-up stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_up_i | input | 1 | Burst enable level |
| band_sel_i | input | 1 | Band choice, 0 low / 1 high |
| ramp_det_i | input | 1 | Ramp-detected flag from comparator |
| sample_sw_o | output | 1 | Detector offset sample switch, 1 closed |
| prebias_sw_o | output | 1 | Pre-bias switch |
| home_sw_o | output | 1 | Home-voltage switch |
| xfer_sw_o | output | 1 | Loop-transfer switch |
| fb_lo_sw_o | output | 1 | Low-band feedback switch |
| fb_hi_sw_o | output | 1 | High-band feedback switch |
| drv_lo_en_o | output | 1 | Low-band driver power-up |
| drv_hi_en_o | output | 1 | High-band driver power-up |
| clamp_lo_o | output | 1 | Low-band output clamp to ground |
| clamp_hi_o | output | 1 | High-band output clamp to ground |
| phase_o | output | 3 | Current phase code (0..4) |

## Verification
A wrong internal state shows at the switch ports in the same cycle, because every control is decoded directly from the phase and band registers. An off-by-one in the shared timer shows as a phase change one cycle early or late at the end of sampling or settle. A stale edge register shows as home-settle being entered from a ramp level that was held across arming. A band register that reloads mid-burst shows as the driver enables swapping on the cycle after band select moves. Each of these errors shows at the ports within one cycle of the event that exposes it.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int unsigned NUM_BANDS = 2;
  localparam int unsigned BAND_W    = $clog2(NUM_BANDS);

  typedef enum logic [2:0] {
    PH_OFF    = 3'd0,
    PH_SAMPLE = 3'd1,
    PH_ARMED  = 3'd2,
    PH_SETTLE = 3'd3,
    PH_LOOP   = 3'd4
  } phase_e;
endpackage

// File: rtl/burst_seq_timer.sv
module burst_seq_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (cnt_q != '1)      cnt_q <= cnt_q + 1'b1;
  end

  // done in the last cycle of the interval
  assign done_o = (cnt_q == limit_i - 1'b1);
endmodule

// File: rtl/burst_seq_band.sv
module burst_seq_band
  import burst_seq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 band_sel_i,
  output logic [NUM_BANDS-1:0] band_oh_o
);
  logic [BAND_W-1:0] band_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      band_q <= '0;
    else if (start_i) band_q <= BAND_W'(band_sel_i);
  end

  for (genvar b = 0; b < NUM_BANDS; b++) begin : g_oh
    assign band_oh_o[b] = (band_q == BAND_W'(b));
  end
endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
#(
  parameter int unsigned SAMPLE_CYC = 8,
  parameter int unsigned SETTLE_CYC = 100,
  parameter int unsigned CNT_W      = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_up_i,
  input  logic             ramp_det_i,
  input  logic             tmr_done_i,
  output phase_e           phase_o,
  output logic             start_o,
  output logic             tmr_clr_o,
  output logic [CNT_W-1:0] tmr_limit_o
);
  localparam logic [CNT_W-1:0] SAMPLE_LIM = CNT_W'(SAMPLE_CYC);
  localparam logic [CNT_W-1:0] SETTLE_LIM = CNT_W'(SETTLE_CYC);

  phase_e phase_q, phase_d;
  logic   ramp_q, ramp_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ramp_q <= 1'b0;
    else         ramp_q <= ramp_det_i;
  end
  assign ramp_evt = ramp_det_i & ~ramp_q;

  always_comb begin
    phase_d = phase_q;
    if (!pwr_up_i) begin
      phase_d = PH_OFF;
    end else begin
      unique case (phase_q)
        PH_OFF:    phase_d = PH_SAMPLE;
        PH_SAMPLE: if (tmr_done_i) phase_d = PH_ARMED;
        PH_ARMED:  if (ramp_evt)   phase_d = PH_SETTLE;
        PH_SETTLE: if (tmr_done_i) phase_d = PH_LOOP;
        PH_LOOP:   phase_d = PH_LOOP;
        default:   phase_d = PH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_OFF;
    else         phase_q <= phase_d;
  end

  assign phase_o     = phase_q;
  assign start_o     = (phase_q == PH_OFF) & pwr_up_i;
  assign tmr_clr_o   = (phase_d != phase_q);
  assign tmr_limit_o = (phase_q == PH_SAMPLE) ? SAMPLE_LIM : SETTLE_LIM;
endmodule

// File: rtl/burst_seq_decode.sv
module burst_seq_decode
  import burst_seq_pkg::*;
(
  input  phase_e               phase_i,
  input  logic [NUM_BANDS-1:0] band_oh_i,
  output logic                 sample_sw_o,
  output logic                 prebias_sw_o,
  output logic                 home_sw_o,
  output logic                 xfer_sw_o,
  output logic [NUM_BANDS-1:0] fb_sw_o,
  output logic [NUM_BANDS-1:0] drv_en_o,
  output logic [NUM_BANDS-1:0] clamp_o
);
  logic active, fb_phase;

  assign active       = (phase_i != PH_OFF);
  assign sample_sw_o  = (phase_i == PH_SAMPLE);
  assign prebias_sw_o = (phase_i == PH_SAMPLE) | (phase_i == PH_ARMED);
  assign home_sw_o    = (phase_i == PH_SETTLE) | (phase_i == PH_LOOP);
  assign xfer_sw_o    = (phase_i == PH_LOOP);
  assign fb_phase     = prebias_sw_o | (phase_i == PH_SETTLE);

  for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
    assign drv_en_o[b] = active & band_oh_i[b];
    assign fb_sw_o[b]  = fb_phase & band_oh_i[b];
    assign clamp_o[b]  = ~(active & band_oh_i[b]);
  end
endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top
  import burst_seq_pkg::*;
#(
  parameter int unsigned SAMPLE_CYC = 8,
  parameter int unsigned SETTLE_CYC = 100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_up_i,
  input  logic       band_sel_i,
  input  logic       ramp_det_i,
  output logic       sample_sw_o,
  output logic       prebias_sw_o,
  output logic       home_sw_o,
  output logic       xfer_sw_o,
  output logic       fb_lo_sw_o,
  output logic       fb_hi_sw_o,
  output logic       drv_lo_en_o,
  output logic       drv_hi_en_o,
  output logic       clamp_lo_o,
  output logic       clamp_hi_o,
  output logic [2:0] phase_o
);
  localparam int unsigned MAX_CYC = (SAMPLE_CYC > SETTLE_CYC) ? SAMPLE_CYC : SETTLE_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  phase_e               phase;
  logic                 start, tmr_clr, tmr_done;
  logic [CNT_W-1:0]     tmr_limit;
  logic [NUM_BANDS-1:0] band_oh, fb_sw, drv_en, clamp;

  burst_seq_ctrl #(
    .SAMPLE_CYC (SAMPLE_CYC),
    .SETTLE_CYC (SETTLE_CYC),
    .CNT_W      (CNT_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pwr_up_i    (pwr_up_i),
    .ramp_det_i  (ramp_det_i),
    .tmr_done_i  (tmr_done),
    .phase_o     (phase),
    .start_o     (start),
    .tmr_clr_o   (tmr_clr),
    .tmr_limit_o (tmr_limit)
  );

  burst_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (tmr_clr),
    .limit_i (tmr_limit),
    .done_o  (tmr_done)
  );

  burst_seq_band u_band (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .band_sel_i (band_sel_i),
    .band_oh_o  (band_oh)
  );

  burst_seq_decode u_dec (
    .phase_i      (phase),
    .band_oh_i    (band_oh),
    .sample_sw_o  (sample_sw_o),
    .prebias_sw_o (prebias_sw_o),
    .home_sw_o    (home_sw_o),
    .xfer_sw_o    (xfer_sw_o),
    .fb_sw_o      (fb_sw),
    .drv_en_o     (drv_en),
    .clamp_o      (clamp)
  );

  assign fb_lo_sw_o  = fb_sw[0];
  assign fb_hi_sw_o  = fb_sw[1];
  assign drv_lo_en_o = drv_en[0];
  assign drv_hi_en_o = drv_en[1];
  assign clamp_lo_o  = clamp[0];
  assign clamp_hi_o  = clamp[1];
  assign phase_o     = phase;
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int unsigned SETTLE_CYC = 100
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwr_up_i,
  input logic       sample_sw_o,
  input logic       prebias_sw_o,
  input logic       home_sw_o,
  input logic       xfer_sw_o,
  input logic       fb_lo_sw_o,
  input logic       fb_hi_sw_o,
  input logic       drv_lo_en_o,
  input logic       drv_hi_en_o,
  input logic       clamp_lo_o,
  input logic       clamp_hi_o,
  input logic [2:0] phase_o
);
  int unsigned settle_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              settle_cnt <= 0;
    else if (phase_o == 3'd3) settle_cnt <= settle_cnt + 1;
    else                      settle_cnt <= 0;
  end

  p_off_clamp_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_up_i |=> (phase_o == 3'd0 && clamp_lo_o && clamp_hi_o && !drv_lo_en_o && !drv_hi_en_o));

  p_band_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({drv_lo_en_o, drv_hi_en_o}) && !(fb_lo_sw_o && fb_hi_sw_o)
    && !(drv_lo_en_o && clamp_lo_o) && !(drv_hi_en_o && clamp_hi_o));

  p_band_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != 3'd0 && pwr_up_i) |=> $stable({drv_lo_en_o, drv_hi_en_o}));

  p_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd0 && pwr_up_i) |=> (phase_o == 3'd1 && sample_sw_o && prebias_sw_o && !home_sw_o));

  p_prebias_home_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prebias_sw_o && home_sw_o));

  p_xfer_fb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_sw_o |-> (home_sw_o && !fb_lo_sw_o && !fb_hi_sw_o));

  p_settle_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd3 && pwr_up_i && settle_cnt == SETTLE_CYC - 1) |=> phase_o == 3'd4);

  p_settle_early_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd3 && settle_cnt < SETTLE_CYC - 1) |=> phase_o != 3'd4);

  p_sample_ignore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd1) |=> (phase_o != 3'd3));

  p_loop_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd4 && pwr_up_i) |=> phase_o == 3'd4);
endmodule

bind burst_seq_top burst_seq_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pwr_up_i     (pwr_up_i),
  .sample_sw_o  (sample_sw_o),
  .prebias_sw_o (prebias_sw_o),
  .home_sw_o    (home_sw_o),
  .xfer_sw_o    (xfer_sw_o),
  .fb_lo_sw_o   (fb_lo_sw_o),
  .fb_hi_sw_o   (fb_hi_sw_o),
  .drv_lo_en_o  (drv_lo_en_o),
  .drv_hi_en_o  (drv_hi_en_o),
  .clamp_lo_o   (clamp_lo_o),
  .clamp_hi_o   (clamp_hi_o),
  .phase_o      (phase_o)
);

// File: tb/burst_seq_top_tb.sv
module burst_seq_top_tb;
  localparam int unsigned SAMPLE_CYC = 8;
  localparam int unsigned SETTLE_CYC = 100;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pwr_up = 1'b0, band_sel = 1'b0, ramp = 1'b0;
  logic sample_sw, prebias_sw, home_sw, xfer_sw, fb_lo, fb_hi;
  logic drv_lo, drv_hi, clamp_lo, clamp_hi;
  logic [2:0] phase;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  burst_seq_top #(.SAMPLE_CYC(SAMPLE_CYC), .SETTLE_CYC(SETTLE_CYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_up_i(pwr_up), .band_sel_i(band_sel),
    .ramp_det_i(ramp), .sample_sw_o(sample_sw), .prebias_sw_o(prebias_sw),
    .home_sw_o(home_sw), .xfer_sw_o(xfer_sw), .fb_lo_sw_o(fb_lo), .fb_hi_sw_o(fb_hi),
    .drv_lo_en_o(drv_lo), .drv_hi_en_o(drv_hi), .clamp_lo_o(clamp_lo),
    .clamp_hi_o(clamp_hi), .phase_o(phase)
  );

  // {phase, sample, prebias, home, xfer, fb_lo, fb_hi, drv_lo, drv_hi, clamp_lo, clamp_hi}
  function automatic logic [12:0] spec(logic [2:0] ph, logic b);
    logic on, fbp;
    on  = (ph != 3'd0);
    fbp = (ph == 3'd1) || (ph == 3'd2) || (ph == 3'd3);
    return {ph, ph == 3'd1, (ph == 3'd1) || (ph == 3'd2), (ph == 3'd3) || (ph == 3'd4),
            ph == 3'd4, fbp && !b, fbp && b, on && !b, on && b, !(on && !b), !(on && b)};
  endfunction

  task automatic expect_st(string req, logic [2:0] ph, logic b);
    logic [12:0] act, exp_v;
    act   = {phase, sample_sw, prebias_sw, home_sw, xfer_sw, fb_lo, fb_hi,
             drv_lo, drv_hi, clamp_lo, clamp_hi};
    exp_v = spec(ph, b);
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s act=%b exp=%b at %0t", req, act, exp_v, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  typedef struct packed {
    logic       band;
    logic [1:0] abort;   // 0 none, 1 in sampling, 2 in armed, 3 in settle
    logic       early;   // ramp pulse during sampling
    logic       flip;    // toggle band select mid-burst
    logic [2:0] arm_wait;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 2'd0, 1'b0, 1'b0, 3'd0},
    '{1'b1, 2'd0, 1'b1, 1'b1, 3'd5},
    '{1'b0, 2'd0, 1'b1, 1'b1, 3'd7},
    '{1'b1, 2'd1, 1'b0, 1'b0, 3'd0},
    '{1'b0, 2'd2, 1'b0, 1'b1, 3'd3},
    '{1'b1, 2'd3, 1'b0, 1'b0, 3'd1},
    '{1'b1, 2'd0, 1'b0, 1'b0, 3'd2}
  };

  task automatic run_vec(vec_t v);
    band_sel = v.band; pwr_up = 1'b1;
    tick();
    expect_st("R4", 3'd1, v.band);
    if (v.flip) band_sel = ~v.band;
    if (v.abort == 2'd1) begin
      pwr_up = 1'b0; tick(); expect_st("R9", 3'd0, v.band); return;
    end
    if (v.early) begin
      ramp = 1'b1; tick(); ramp = 1'b0;
      repeat (SAMPLE_CYC - 2) tick();
    end else begin
      repeat (SAMPLE_CYC - 1) tick();
    end
    expect_st("R5", 3'd1, v.band);
    tick();
    expect_st("R5", 3'd2, v.band);
    repeat (v.arm_wait) tick();
    expect_st(v.early ? "R8" : "R3", 3'd2, v.band);
    if (v.abort == 2'd2) begin
      pwr_up = 1'b0; tick(); expect_st("R9", 3'd0, v.band); return;
    end
    ramp = 1'b1; tick(); ramp = 1'b0;
    expect_st(v.flip ? "R2" : "R6", 3'd3, v.band);
    if (v.abort == 2'd3) begin
      pwr_up = 1'b0; tick(); expect_st("R9", 3'd0, v.band); return;
    end
    repeat (SETTLE_CYC - 1) tick();
    expect_st("R7", 3'd3, v.band);
    tick();
    expect_st("R7", 3'd4, v.band);
    ramp = 1'b1; tick(); ramp = 1'b0;
    expect_st("R8", 3'd4, v.band);
    repeat (5) tick();
    expect_st("R10", 3'd4, v.band);
    pwr_up = 1'b0; tick();
    expect_st("R9", 3'd0, v.band);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) tick();
    expect_st("R1", 3'd0, 1'b0);   // in reset
    rst_ni = 1'b1;
    tick();
    expect_st("R1", 3'd0, 1'b0);

    // ramp while disabled has no effect
    ramp = 1'b1; tick(); ramp = 1'b0; tick();
    expect_st("R8", 3'd0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      run_vec(VEC[i]);
      repeat (2) tick();
    end

    // ramp level held across arming is not an edge
    band_sel = 1'b0; pwr_up = 1'b1; ramp = 1'b1;
    repeat (SAMPLE_CYC + 3) tick();
    expect_st("R8", 3'd2, 1'b0);
    ramp = 1'b0; tick();
    expect_st("R8", 3'd2, 1'b0);
    ramp = 1'b1; tick(); ramp = 1'b0;
    expect_st("R6", 3'd3, 1'b0);

    // asynchronous reset mid-burst
    #3 rst_ni = 1'b0; #1;
    expect_st("R1", 3'd0, 1'b0);
    pwr_up = 1'b0;
    tick(); rst_ni = 1'b1; tick();
    expect_st("R1", 3'd0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule